// File: doc/BRIEF.md
# Conversion Sample Queue

This block buffers completed converter samples so that software or a DMA engine can collect them later. Each time the converter signals a finished conversion and capture is enabled, one formatted entry goes into a four-deep first-in first-out store. An entry holds one of two things. The first is the full 12-bit sample. The second is the sample narrowed to its top eight bits, for transfers into byte buffers. Either form can carry the conversion's error bit at a fixed position.

A read strobe removes the oldest entry, and the entry's value is visible on the read data port during that same cycle. The occupancy count, the full and empty indications, and two sticky fault flags are always visible. The fault flags record a sample dropped on a full store and a read of an empty store. The occupancy count is compared with a programmable threshold. That comparison drives a raw interrupt and, when enabled, a DMA request. An interrupt enable and an interrupt force combine with the raw interrupt to give the final interrupt status.

The occupancy is tracked by a three-state machine. The states are `Q_EMPTY`, `Q_PARTIAL` and `Q_FULL`. The transitions are:
- fill: `Q_EMPTY`→`Q_PARTIAL` on an accepted write.
- drain: `Q_PARTIAL`→`Q_EMPTY` when the last entry is read.
- top-off: `Q_PARTIAL`→`Q_FULL` when a write takes the count to the depth.
- release: `Q_FULL`→`Q_PARTIAL` on a read without a write.

Every other case holds the current state.

Top module: `sample_queue`

## Requirements
- R1: An entry is written only in a cycle where `conv_done` and `cap_en` are both 1. With `cap_en` at 0, conversions leave the level unchanged.
- R2: With `byte_mode` at 0, entry bits 11:0 hold `conv_result` unchanged.
- R3: With `byte_mode` at 1, entry bits 7:0 hold `conv_result[11:4]` and entry bits 11:8 read 0.
- R4: With `err_tag` at 1, entry bit 15 holds `conv_err` in both modes. With `err_tag` at 0, bit 15 reads 0. Bits 14:12 always read 0.
- R5: Entries are read out in the order they were written. `level` reports the count (0 to 4). `full` is 1 exactly at 4 entries and `empty` is 1 exactly at 0 entries. A read and a write in the same cycle on a full store are both accepted.
- R6: A write on a full store without a read in the same cycle discards the new sample, leaves the contents unchanged and sets `ovf_flag` from the next cycle. The flag stays set until it is cleared.
- R7: A read on an empty store shows 0 on `rd_data`, leaves the level at 0 and sets `unf_flag` from the next cycle. The flag stays set until it is cleared.
- R8: A 1 on `clr_ovf` or `clr_unf` clears the matching flag at the next edge. If a new fault occurs in the same cycle, the set takes priority.
- R9: `irq_raw` is 1 whenever `level` is greater than or equal to `thresh`, so a threshold of 0 keeps it high.
- R10: `dma_req` equals `irq_raw` while `dma_en` is 1 and is 0 otherwise.
- R11: `irq_out` equals (`irq_raw` AND `irq_en`) OR `irq_force`.
- R12: After reset the store is empty, the level is 0, and both fault flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_done | input | 1 | One-cycle pulse marking a finished conversion |
| conv_result | input | 12 | Sample value of the finished conversion |
| conv_err | input | 1 | Error indication of the finished conversion |
| cap_en | input | 1 | Capture enable for the store |
| byte_mode | input | 1 | Store the upper eight sample bits only |
| err_tag | input | 1 | Store the error indication at entry bit 15 |
| dma_en | input | 1 | Enable the DMA request output |
| thresh | input | 4 | Occupancy threshold |
| rd_pop | input | 1 | Read strobe, removes the oldest entry |
| rd_data | output | 16 | Oldest entry, or 0 when empty |
| level | output | 4 | Number of stored entries |
| full | output | 1 | Store holds four entries |
| empty | output | 1 | Store holds no entries |
| ovf_flag | output | 1 | Sticky flag for a dropped sample |
| unf_flag | output | 1 | Sticky flag for a read of an empty store |
| clr_ovf | input | 1 | Write-1 clear of `ovf_flag` |
| clr_unf | input | 1 | Write-1 clear of `unf_flag` |
| irq_en | input | 1 | Interrupt enable |
| irq_force | input | 1 | Interrupt force |
| irq_raw | output | 1 | Level at or above threshold |
| irq_out | output | 1 | Final interrupt status |
| dma_req | output | 1 | DMA request |

## Verification
The bench builds the block with its default parameters: depth 4, a 12-bit sample, a shift of 4 and a 4-bit threshold. With a depth of four, a handful of conversions reach `Q_FULL`, overflow and a simultaneous read and write on a full store. The same small depth lets the threshold sweep cover every level from 0 to 4 against thresholds of 0, 2, 4 and 5, including the setting of 5 that no level can reach. The 12-bit sample with a shift of 4 makes the narrowed value, and the bit-15 error tag sitting above it, easy to predict in the bench's model.

// File: rtl/sq_pkg.sv
package sq_pkg;
    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } q_state_t;
endpackage

// File: rtl/sq_format.sv
module sq_format #(
    parameter int RES_W   = 12,
    parameter int ENTRY_W = 16,
    parameter int SHIFT   = 4,
    parameter int ERR_BIT = 15
) (
    input  logic [RES_W-1:0]   res,
    input  logic               err,
    input  logic               byte_mode,
    input  logic               err_tag,
    output logic [ENTRY_W-1:0] entry
);
    always_comb begin
        entry = '0;
        if (byte_mode) begin
            entry[RES_W-1:0] = res >> SHIFT;
        end else begin
            entry[RES_W-1:0] = res;
        end
        if (err_tag) begin
            entry[ERR_BIT] = err;
        end
    end
endmodule

// File: rtl/sq_store.sv
module sq_store
    import sq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int W     = 16,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          push_dropped,
    output logic          pop_missed
);
    q_state_t state, state_nx;
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign do_pop       = pop && !empty;
    assign do_push      = push && (!full || pop);
    assign push_dropped = push && full && !pop;
    assign pop_missed   = pop && empty;

    // occupancy state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= Q_EMPTY;
        else        state <= state_nx;
    end

    // transitions: fill, drain, top-off, release
    always_comb begin
        state_nx = state;
        unique case (state)
            Q_EMPTY: begin
                if (do_push) state_nx = (DEPTH == 1) ? Q_FULL : Q_PARTIAL;
            end
            Q_PARTIAL: begin
                if (do_push && !do_pop && count == CW'(DEPTH - 1))
                    state_nx = Q_FULL;
                else if (do_pop && !do_push && count == CW'(1))
                    state_nx = Q_EMPTY;
            end
            Q_FULL: begin
                if (do_pop && !do_push)
                    state_nx = (DEPTH == 1) ? Q_EMPTY : Q_PARTIAL;
            end
            default: state_nx = Q_EMPTY;
        endcase
    end

    // outputs from state
    always_comb begin
        full  = 1'b0;
        empty = 1'b0;
        unique case (state)
            Q_EMPTY:   empty = 1'b1;
            Q_PARTIAL: ;
            Q_FULL:    full = 1'b1;
            default:   empty = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            count <= count + {{(CW-1){1'b0}}, do_push} - {{(CW-1){1'b0}}, do_pop};
            if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    assign dout = empty ? '0 : mem[rd_ptr];

    a_r5_state_match: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == Q_FULL) == (count == CW'(DEPTH))) &&
        ((state == Q_EMPTY) == (count == '0)));
    a_r5_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    a_r6_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);
endmodule

// File: rtl/sq_alert.sv
module sq_alert #(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_dropped,
    input  logic             pop_missed,
    input  logic             clr_ovf,
    input  logic             clr_unf,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] thresh,
    input  logic             dma_en,
    input  logic             irq_en,
    input  logic             irq_force,
    output logic             ovf_flag,
    output logic             unf_flag,
    output logic             irq_raw,
    output logic             irq_out,
    output logic             dma_req
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
        end else begin
            if (push_dropped)  ovf_flag <= 1'b1;
            else if (clr_ovf)  ovf_flag <= 1'b0;
            if (pop_missed)    unf_flag <= 1'b1;
            else if (clr_unf)  unf_flag <= 1'b0;
        end
    end

    assign irq_raw = (level >= thresh);
    assign dma_req = dma_en & irq_raw;
    assign irq_out = (irq_raw & irq_en) | irq_force;

    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr_ovf) |=> ovf_flag);
    a_r7_unf_set: assert property (@(posedge clk) disable iff (!rst_n)
        pop_missed |=> unf_flag);
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_unf && !pop_missed) |=> !unf_flag);
endmodule

// File: rtl/sample_queue.sv
module sample_queue #(
    parameter int DEPTH   = 4,
    parameter int RES_W   = 12,
    parameter int ENTRY_W = 16,
    parameter int SHIFT   = 4,
    parameter int LVL_W   = 4,
    localparam int ERR_BIT = ENTRY_W - 1,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               conv_done,
    input  logic [RES_W-1:0]   conv_result,
    input  logic               conv_err,
    input  logic               cap_en,
    input  logic               byte_mode,
    input  logic               err_tag,
    input  logic               dma_en,
    input  logic [LVL_W-1:0]   thresh,
    input  logic               rd_pop,
    output logic [ENTRY_W-1:0] rd_data,
    output logic [LVL_W-1:0]   level,
    output logic               full,
    output logic               empty,
    output logic               ovf_flag,
    output logic               unf_flag,
    input  logic               clr_ovf,
    input  logic               clr_unf,
    input  logic               irq_en,
    input  logic               irq_force,
    output logic               irq_raw,
    output logic               irq_out,
    output logic               dma_req
);
    logic [ENTRY_W-1:0] entry;
    logic [CW-1:0]      count;
    logic               push, push_dropped, pop_missed;

    assign push  = conv_done & cap_en;
    assign level = LVL_W'(count);

    sq_format #(.RES_W(RES_W), .ENTRY_W(ENTRY_W), .SHIFT(SHIFT), .ERR_BIT(ERR_BIT)) u_fmt (
        .res(conv_result), .err(conv_err), .byte_mode(byte_mode),
        .err_tag(err_tag), .entry(entry)
    );

    sq_store #(.DEPTH(DEPTH), .W(ENTRY_W)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .din(entry), .pop(rd_pop),
        .dout(rd_data), .count(count), .full(full), .empty(empty),
        .push_dropped(push_dropped), .pop_missed(pop_missed)
    );

    sq_alert #(.LVL_W(LVL_W)) u_alert (
        .clk(clk), .rst_n(rst_n), .push_dropped(push_dropped),
        .pop_missed(pop_missed), .clr_ovf(clr_ovf), .clr_unf(clr_unf),
        .level(level), .thresh(thresh), .dma_en(dma_en), .irq_en(irq_en),
        .irq_force(irq_force), .ovf_flag(ovf_flag), .unf_flag(unf_flag),
        .irq_raw(irq_raw), .irq_out(irq_out), .dma_req(dma_req)
    );

    a_r1_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en && !rd_pop) |=> $stable(level));
    a_r7_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_pop) |-> (rd_data == '0));
endmodule

// File: tb/sim_sample_queue.sv
module sim_sample_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_done = 0, conv_err = 0, cap_en = 0, byte_mode = 0, err_tag = 0;
    logic        dma_en = 0, rd_pop = 0, clr_ovf = 0, clr_unf = 0, irq_en = 0, irq_force = 0;
    logic [11:0] conv_result = '0;
    logic [3:0]  thresh = '0;
    logic [15:0] rd_data;
    logic [3:0]  level;
    logic        full, empty, ovf_flag, unf_flag, irq_raw, irq_out, dma_req;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int unsigned q[$];
    bit m_ovf = 0, m_unf = 0;

    always #4 clk = ~clk;

    sample_queue u0 (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_result(conv_result),
        .conv_err(conv_err), .cap_en(cap_en), .byte_mode(byte_mode), .err_tag(err_tag),
        .dma_en(dma_en), .thresh(thresh), .rd_pop(rd_pop), .rd_data(rd_data),
        .level(level), .full(full), .empty(empty), .ovf_flag(ovf_flag),
        .unf_flag(unf_flag), .clr_ovf(clr_ovf), .clr_unf(clr_unf), .irq_en(irq_en),
        .irq_force(irq_force), .irq_raw(irq_raw), .irq_out(irq_out), .dma_req(dma_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int unsigned fmt(input logic [11:0] r, input bit e);
        int unsigned v;
        v = byte_mode ? int'(r) / 16 : int'(r);
        if (err_tag && e) v = v + 32768;
        return v;
    endfunction

    // one cycle: drive inputs, compare against model, advance model at the edge
    task automatic step(input bit d, input logic [11:0] r, input bit e,
                        input bit p, input bit co, input bit cu);
        bit raw;
        int unsigned sz;
        conv_done = d; conv_result = r; conv_err = e;
        rd_pop = p; clr_ovf = co; clr_unf = cu;
        #1;
        sz  = q.size();
        raw = (sz >= int'(thresh));
        chk("R2/R3/R4/R7 rd_data", {16'd0, rd_data}, (sz != 0) ? q[0] : 0);
        chk("R5 level", {28'd0, level}, sz);
        chk("R5 full", {31'd0, full}, {31'd0, sz == 4});
        chk("R5 empty", {31'd0, empty}, {31'd0, sz == 0});
        chk("R6 ovf_flag", {31'd0, ovf_flag}, {31'd0, m_ovf});
        chk("R7 unf_flag", {31'd0, unf_flag}, {31'd0, m_unf});
        chk("R9 irq_raw", {31'd0, irq_raw}, {31'd0, raw});
        chk("R10 dma_req", {31'd0, dma_req}, {31'd0, dma_en && raw});
        chk("R11 irq_out", {31'd0, irq_out}, {31'd0, (raw && irq_en) || irq_force});
        @(posedge clk);
        // R8: set wins over clear
        if (p && sz == 0) m_unf = 1; else if (cu) m_unf = 0;
        if (p && sz != 0) void'(q.pop_front());
        if (d && cap_en) begin
            if (sz == 4 && !p) m_ovf = 1;
            else q.push_back(fmt(r, e));
        end
        if (!(d && cap_en && sz == 4 && !p) && co) m_ovf = 0;
        @(negedge clk);
        conv_done = 0; rd_pop = 0; clr_ovf = 0; clr_unf = 0;
    endtask

    task automatic idle();
        step(0, 12'h000, 0, 0, 0, 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        chk("R12 level", {28'd0, level}, 0);
        chk("R12 empty", {31'd0, empty}, 1);
        chk("R12 flags", {30'd0, ovf_flag, unf_flag}, 0);
        thresh = 4'd5;
        idle();
        // R1 capture disabled
        step(1, 12'hABC, 0, 0, 0, 0);
        step(1, 12'h123, 1, 0, 0, 0);
        idle();
        // R2 full-width, tag off (R4 bit15 reads 0)
        cap_en = 1;
        step(1, 12'hABC, 1, 0, 0, 0);
        step(1, 12'hFFF, 0, 0, 0, 0);
        step(0, 12'h0, 0, 1, 0, 0);
        step(0, 12'h0, 0, 1, 0, 0);
        idle();
        // R3 byte mode, R4 tag on in both modes
        err_tag = 1; byte_mode = 1;
        step(1, 12'hABC, 1, 0, 0, 0);
        step(1, 12'h5A7, 0, 0, 0, 0);
        byte_mode = 0;
        step(1, 12'h8F1, 1, 0, 0, 0);
        step(1, 12'h00F, 0, 0, 0, 0);
        // R6 overflow on full, discard
        step(1, 12'h777, 1, 0, 0, 0);
        idle();
        // R5 simultaneous read and write on full
        step(1, 12'h321, 0, 1, 0, 0);
        // R8 clear with simultaneous overflow: set wins
        step(1, 12'h444, 0, 0, 1, 0);
        step(0, 12'h0, 0, 0, 1, 0);
        idle();
        // drain, then R7 underflow
        for (int i = 0; i < 5; i++) step(0, 12'h0, 0, 1, 0, 0);
        idle();
        step(0, 12'h0, 0, 1, 0, 1);
        step(0, 12'h0, 0, 0, 0, 1);
        idle();
        // R9 R10 R11 threshold sweep
        for (int t = 0; t < 4; t++) begin
            thresh = (t == 0) ? 4'd0 : (t == 1) ? 4'd2 : (t == 2) ? 4'd4 : 4'd5;
            dma_en = t[0]; irq_en = t[1]; irq_force = (t == 3);
            idle();
            for (int k = 0; k < 4; k++) step(1, 12'(k * 100 + 7), k[0], 0, 0, 0);
            idle();
            irq_force = 0; irq_en = 1; dma_en = 1;
            idle();
            for (int k = 0; k < 4; k++) step(0, 12'h0, 0, 1, 0, 0);
            idle();
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule